// File: doc/BRIEF.md
# Memory Protection Region Register Bank

This block stores the setup for a parameterised set of memory protection regions, from one up to sixty-four. Each region owns an 8-bit setup byte and a 32-bit boundary word. Software reaches them through one register port with an address, write data, a write strobe and combinational read data. Every region's byte and word also drive wide parallel outputs, so that a separate range checker can compare them with addresses in the same cycle.

Each setup byte carries read, write and execute permission flags, a 2-bit range-matching mode and a sticky lock flag. Once the lock flag is set, software cannot change that region again until the synchronous reset. A locked region whose mode is top-of-range also freezes the boundary word of the region just below it, because that word is its lower bound. Setup bytes are packed four to a 32-bit register, and one write to such a register updates only its unlocked bytes. Writes that are blocked are dropped without any indication.

Top module: `pmp_reg_bank`

## Requirements
- R1: With NUM_REGIONS regions, region k drives its setup byte on `region_cfg[8k+7:8k]` and its full 32-bit boundary word on `region_addr[32k+31:32k]`. The boundary word is stored as physical address bits 33:2.
- R2: Register map. When `csr_addr[6]` is 1, `csr_addr[5:0]` selects the boundary word of region `csr_addr[5:0]`. When `csr_addr[6]` is 0, `csr_addr[5:0]` selects packed setup register g, which holds the bytes of regions 4g to 4g+3, with region 4g+j in bits 8j+7:8j.
- R3: Setup byte layout. Bit 0 is read, bit 1 is write, bit 2 is execute. Bits 4:3 hold the mode: 00 off, 01 top-of-range, 10 four-byte, 11 power-of-two. Bit 7 is the lock. A write to an unlocked byte stores these bits as given.
- R4: Setup byte bits 6:5 always read as 0, whatever value is written to them.
- R5: A setup byte whose bit 7 is 1 ignores every write until reset.
- R6: The boundary word of a locked region ignores every write until reset.
- R7: A write to a packed setup register changes only the unlocked bytes in it. Locked bytes keep their value within the same write.
- R8: When region k+1 is locked with mode 01, writes to the boundary word of region k are ignored. When region k+1 is locked with any other mode, region k's boundary word stays writable.
- R9: While `rst` is high at a rising edge, every setup byte, including its lock, and every boundary word are cleared to 0. Locked regions become writable again after reset.
- R10: A write takes effect at the rising edge where `csr_we` is high. Before that edge the outputs keep their old value. `csr_rdata` always returns the current contents of the selected register.
- R11: Reads of a region or setup byte that is not implemented return 0. Writes to them change no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 7 | Register select: bank bit 6, index bits 5:0 |
| csr_wdata | input | 32 | Write data |
| csr_we | input | 1 | Write strobe |
| csr_rdata | output | 32 | Contents of the selected register |
| region_cfg | output | 8*NUM_REGIONS | Setup bytes of all regions |
| region_addr | output | 32*NUM_REGIONS | Boundary words of all regions |

## Verification
Byte packing and lock enforcement act in the same cycle when one write to a packed setup register covers both locked and unlocked bytes. The bench locks alternate regions of one group, then writes all-zero and all-ones data to that register. It expects the unlocked bytes to take the new value (masked per R4) while the locked bytes keep theirs. A second coincidence arises when a boundary write is judged against a neighbour's lock and mode: the bench locks neighbours with top-of-range and power-of-two modes and checks which of the two words below them still change. Every write is followed by a comparison of all parallel outputs and a read of every register address against a model built from the requirements.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

    localparam int CFG_W      = 8;
    localparam int WORD_W     = 32;
    localparam int CSR_AW     = 7;
    localparam int PER_GROUP  = WORD_W / CFG_W;
    localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 8'h9F;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'b00,
        MATCH_TOR   = 2'b01,
        MATCH_NA4   = 2'b10,
        MATCH_NAPOT = 2'b11
    } match_mode_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic        exec;
        logic        wr;
        logic        rd;
    } region_cfg_t;

    typedef struct packed {
        logic       addr_bank;
        logic [5:0] index;
    } csr_sel_t;

    function automatic region_cfg_t cfg_from_byte(input logic [CFG_W-1:0] b);
        return region_cfg_t'(b & CFG_KEEP_MASK);
    endfunction

    function automatic logic guards_lower(input logic lock, input match_mode_e mode);
        return lock && (mode == MATCH_TOR);
    endfunction

endpackage

// File: rtl/pmp_cfg_slot.sv
module pmp_cfg_slot
    import pmp_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grp_wr,
    input  logic [CFG_W-1:0]  wbyte,
    output region_cfg_t       cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (grp_wr && !cfg_q.lock) begin
            cfg_q <= cfg_from_byte(wbyte);
        end
    end

    assert_cfg_lock_hold_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_q.lock |=> $stable(cfg_q));

    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_q.rsvd == 2'b00);

    assert_cfg_reset_R9: assert property (@(posedge clk)
        rst |=> cfg_q == '0);

endmodule

// File: rtl/pmp_addr_slot.sv
module pmp_addr_slot
    import pmp_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic              self_lock,
    input  logic              next_lock,
    input  match_mode_e       next_mode,
    output logic [WORD_W-1:0] addr_q
);

    logic frozen;

    always_comb begin
        frozen = self_lock || guards_lower(next_lock, next_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (wr_hit && !frozen) begin
            addr_q <= wdata;
        end
    end

    assert_addr_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        self_lock |=> $stable(addr_q));

    assert_tor_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (next_lock && next_mode == MATCH_TOR) |=> $stable(addr_q));

    assert_addr_reset_R9: assert property (@(posedge clk)
        rst |=> addr_q == '0);

endmodule

// File: rtl/pmp_csr_rmux.sv
module pmp_csr_rmux
    import pmp_bank_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  csr_sel_t            sel,
    input  logic [N*CFG_W-1:0]  cfg_flat,
    input  logic [N*WORD_W-1:0] addr_flat,
    output logic [WORD_W-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        if (sel.addr_bank) begin
            if (int'(sel.index) < N) begin
                rdata = addr_flat[int'(sel.index)*WORD_W +: WORD_W];
            end
        end else begin
            for (int j = 0; j < PER_GROUP; j++) begin
                if (int'(sel.index)*PER_GROUP + j < N) begin
                    rdata[j*CFG_W +: CFG_W] =
                        cfg_flat[(int'(sel.index)*PER_GROUP + j)*CFG_W +: CFG_W];
                end
            end
        end
    end

    assert_unimpl_read_R11: assert property (@(posedge clk) disable iff (rst)
        (sel.addr_bank && int'(sel.index) >= N) |-> rdata == '0);

endmodule

// File: rtl/pmp_reg_bank.sv
module pmp_reg_bank
    import pmp_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [6:0]                    csr_addr,
    input  logic [31:0]                   csr_wdata,
    input  logic                          csr_we,
    output logic [31:0]                   csr_rdata,
    output logic [NUM_REGIONS*8-1:0]      region_cfg,
    output logic [NUM_REGIONS*32-1:0]     region_addr
);

    localparam int NUM_GROUPS = (NUM_REGIONS + PER_GROUP - 1) / PER_GROUP;

    csr_sel_t    sel;
    region_cfg_t cfg_arr  [NUM_REGIONS];
    logic [WORD_W-1:0] addr_arr [NUM_REGIONS];

    always_comb begin
        sel = csr_sel_t'(csr_addr);
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        logic        grp_wr;
        logic        addr_wr;
        logic        nxt_lock;
        match_mode_e nxt_mode;

        always_comb begin
            grp_wr  = csr_we && !sel.addr_bank && (sel.index == 6'(i / PER_GROUP));
            addr_wr = csr_we &&  sel.addr_bank && (sel.index == 6'(i));
        end

        if (i + 1 < NUM_REGIONS) begin : g_nbr
            always_comb begin
                nxt_lock = cfg_arr[i+1].lock;
                nxt_mode = cfg_arr[i+1].mode;
            end
        end else begin : g_top
            always_comb begin
                nxt_lock = 1'b0;
                nxt_mode = MATCH_OFF;
            end
        end

        pmp_cfg_slot u_cfg (
            .clk    (clk),
            .rst    (rst),
            .grp_wr (grp_wr),
            .wbyte  (csr_wdata[(i % PER_GROUP)*CFG_W +: CFG_W]),
            .cfg_q  (cfg_arr[i])
        );

        pmp_addr_slot u_addr (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (addr_wr),
            .wdata     (csr_wdata),
            .self_lock (cfg_arr[i].lock),
            .next_lock (nxt_lock),
            .next_mode (nxt_mode),
            .addr_q    (addr_arr[i])
        );

        assign region_cfg[i*CFG_W +: CFG_W]    = cfg_arr[i];
        assign region_addr[i*WORD_W +: WORD_W] = addr_arr[i];
    end

    pmp_csr_rmux #(.N(NUM_REGIONS)) u_rmux (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .cfg_flat  (region_cfg),
        .addr_flat (region_addr),
        .rdata     (csr_rdata)
    );

    initial begin
        assert_param_range_R1: assert (NUM_REGIONS >= 1 && NUM_REGIONS <= 64 && NUM_GROUPS <= 16)
            else $error("NUM_REGIONS out of range");
    end

endmodule

// File: tb/pmp_reg_bank_test.sv
`timescale 1ns/1ps
module pmp_reg_bank_test;

    localparam int NR = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [6:0]        csr_addr = '0;
    logic [31:0]       csr_wdata = '0;
    logic              csr_we = 1'b0;
    logic [31:0]       csr_rdata;
    logic [NR*8-1:0]   region_cfg;
    logic [NR*32-1:0]  region_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  exp_cfg  [NR];
    logic [31:0] exp_addr [NR];

    always #2.5 clk = ~clk;

    pmp_reg_bank #(.NUM_REGIONS(NR)) uut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rdata(csr_rdata),
        .region_cfg(region_cfg), .region_addr(region_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] r = '0;
        int idx = a % 64;
        if (a >= 64) begin
            if (idx < NR) r = exp_addr[idx];
        end else begin
            for (int j = 0; j < 4; j++)
                if (idx*4 + j < NR) r[j*8 +: 8] = exp_cfg[idx*4 + j];
        end
        return r;
    endfunction

    function automatic void model_write(input int a, input logic [31:0] d);
        int idx = a % 64;
        if (a >= 64) begin
            if (idx < NR && !exp_cfg[idx][7] &&
                !(idx + 1 < NR && exp_cfg[idx+1][7] && exp_cfg[idx+1][4:3] == 2'b01))
                exp_addr[idx] = d;
        end else begin
            for (int j = 0; j < 4; j++)
                if (idx*4 + j < NR && !exp_cfg[idx*4 + j][7])
                    exp_cfg[idx*4 + j] = d[j*8 +: 8] & 8'h9F;
        end
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = 7'(a); csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < NR; r++) begin exp_cfg[r] = '0; exp_addr[r] = '0; end
    endtask

    task automatic verify_all(input string req);
        for (int r = 0; r < NR; r++) begin
            check(req, 32'(region_cfg[r*8 +: 8]), 32'(exp_cfg[r]));
            check(req, region_addr[r*32 +: 32], exp_addr[r]);
        end
        for (int a = 0; a < 128; a++) begin
            csr_addr = 7'(a);
            #1;
            check("R10", csr_rdata, exp_read(a));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        verify_all("R9");

        // R1: a single boundary word lands on its own output slice
        wr(64 + 3, 32'hCAFE_0123);
        check("R1", region_addr[3*32 +: 32], 32'hCAFE_0123);
        verify_all("R1");

        // R3 / R4: sweep every unlocked byte value through groups 0 and 1
        for (int v = 0; v < 128; v++) begin
            logic [7:0] b = 8'(v);
            wr(0, {~b & 8'h7F, b ^ 8'h55, b ^ 8'h2A, b});
            wr(1, {b ^ 8'h11, b ^ 8'h66, b ^ 8'h33, b ^ 8'h4C});
            verify_all((b[6] | b[5]) ? "R4" : "R3");
        end

        // R2 / R11: every register address, implemented or not
        do_reset();
        for (int a = 0; a < 128; a++) begin
            logic [31:0] d = 32'h1357_9BDF * 32'(a + 1);
            if (a < 64) d = d & 32'h7F7F_7F7F;
            wr(a, d);
            if ((a >= 64 && a - 64 >= NR) || (a < 64 && a * 4 >= NR)) begin
                csr_addr = 7'(a);
                #1;
                check("R11", csr_rdata, 32'h0);
                verify_all("R11");
            end else begin
                verify_all("R2");
            end
        end

        // R10: a write is not visible before its clock edge
        do_reset();
        @(negedge clk);
        csr_addr = 7'(64 + 2); csr_wdata = 32'h0BAD_F00D; csr_we = 1'b1;
        #1;
        check("R10", region_addr[2*32 +: 32], 32'h0);
        @(negedge clk);
        csr_we = 1'b0;
        model_write(64 + 2, 32'h0BAD_F00D);
        check("R10", region_addr[2*32 +: 32], 32'h0BAD_F00D);

        // Lock scenario
        do_reset();
        for (int r = 0; r < NR; r++) wr(64 + r, 32'h1000_0000 + 32'(r));
        verify_all("R2");
        wr(0, 32'h9A05_8F03);   // e1 locked TOR, e3 locked NAPOT
        verify_all("R3");
        wr(0, 32'h0000_0000);
        check("R7", 32'(region_cfg[1*8 +: 8]), 32'h8F);
        check("R7", 32'(region_cfg[0*8 +: 8]), 32'h00);
        verify_all("R7");
        wr(0, 32'h7F7F_7F7F);
        check("R5", 32'(region_cfg[3*8 +: 8]), 32'h9A);
        check("R7", 32'(region_cfg[2*8 +: 8]), 32'h1F);
        verify_all("R5");
        wr(64 + 0, 32'hAAAA_0000);
        check("R8", region_addr[0*32 +: 32], 32'h1000_0000);
        verify_all("R8");
        wr(64 + 1, 32'hAAAA_0001);
        check("R6", region_addr[1*32 +: 32], 32'h1000_0001);
        verify_all("R6");
        wr(64 + 2, 32'hAAAA_0002);
        check("R8", region_addr[2*32 +: 32], 32'hAAAA_0002);
        wr(64 + 3, 32'hAAAA_0003);
        check("R6", region_addr[3*32 +: 32], 32'h1000_0003);
        wr(64 + 4, 32'hAAAA_0004);
        verify_all("R2");
        wr(1, 32'h0000_0088);   // e4 locked TOR
        wr(64 + 5, 32'hBBBB_0005);
        check("R8", region_addr[5*32 +: 32], 32'hBBBB_0005);
        wr(1, 32'hFFFF_FFFF);
        check("R5", 32'(region_cfg[4*8 +: 8]), 32'h88);
        check("R4", 32'(region_cfg[5*8 +: 8]), 32'h9F);
        wr(64 + 5, 32'hCCCC_0005);
        check("R6", region_addr[5*32 +: 32], 32'hBBBB_0005);
        verify_all("R6");

        // R9: reset releases every lock
        do_reset();
        verify_all("R9");
        wr(64 + 0, 32'h0000_DEAD);
        wr(0, 32'h0000_0011);
        check("R9", region_addr[0*32 +: 32], 32'h0000_DEAD);
        verify_all("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule